// File: doc/BRIEF.md
# Paged Data Memory Address Decoder

This block sits between a small CPU core and its data space. The core issues an 8-bit direct address with a read or write strobe. The decoder combines that offset with the active page to form a 10-bit physical location in a 576-byte space. It then steers the access to one of four places: the RAM array, the peripheral register bus, its own page-select register, or nowhere when the location does not exist.

Page 0 is split in two. Offsets 0x00–0xBF are RAM, and offsets 0xC0–0xFF form a 64-entry control window on the register bus. Page 1 is 256 bytes of RAM at 0x100–0x1FF. Page 2 holds only 64 bytes, at 0x200–0x23F.

A small two-state machine handles the global page flag:

- **PG_FORCED0** is the reset state. In this state every access goes to page 0.
- **PG_LATCHED** is entered from PG_FORCED0 on a `gflag_set` pulse, provided `gflag_clr` is not also high. On entry it captures the current page-select value as the active page.
- A further `gflag_set` pulse while in PG_LATCHED reloads the active page from the page-select register.
- A `gflag_clr` pulse returns the machine to PG_FORCED0 from either state. When both inputs are high in the same cycle, the clear wins.

Software can therefore rewrite the page-select register at any time, but the new value only steers accesses after the next set pulse.

Top module: `paged_dmem_decoder`

## Requirements
- R1: After reset the machine is in PG_FORCED0, the page-select register holds 0, and `cpu_rdata` is 0x00.
- R2: With active page 0, offsets 0x00–0xBF drive the RAM port with `ram_addr` equal to the offset. A write pulses `ram_we`, and a read (`cpu_rd` high with `cpu_wr` low) pulses `ram_re`.
- R3: With active page 0, offsets 0xC0–0xFF other than 0xE1 go to the register bus with `reg_addr` = offset − 0xC0. The RAM strobes stay low for these accesses.
- R4: On active page 0, offset 0xE1 is the page-select register. A write stores `cpu_wdata[2:0]`. A read returns {5'b00000, stored value}. Neither the RAM strobes nor the register-bus strobes fire for this offset.
- R5: While in PG_FORCED0, every access decodes as page 0, whatever the page-select register holds.
- R6: `gflag_set` loads the active page from the page-select register. Later writes to that register have no effect until the next set pulse. A cycle with both `gflag_set` and `gflag_clr` high leaves the machine in PG_FORCED0.
- R7: Active page 1 maps offset n to `ram_addr` 0x100+n for every n. Active page 2 maps offsets 0x00–0x3F to `ram_addr` 0x200+n.
- R8: An access is treated as a hole in two cases: on page 2 at offsets 0x40–0xFF, or with an active page code of 3–7. For a hole, `unimpl` is high in the access cycle, no RAM or register strobe fires, and a read returns 0xFF.
- R9: `cpu_rdata` is updated at the clock edge that ends a read cycle and holds its value in every cycle without a read. A cycle with both strobes high counts as a write only.
- R10: `unimpl` is low in any cycle without an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 8 | Direct data address (page offset) |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| unimpl | output | 1 | Current access targets a nonexistent location |
| gflag_set | input | 1 | Set the global page flag and latch the page |
| gflag_clr | input | 1 | Clear the global page flag (force page 0) |
| ram_addr | output | 10 | Physical RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle as the address |
| reg_addr | output | 6 | Control-window register index |
| reg_we | output | 1 | Register-bus write enable |
| reg_re | output | 1 | Register-bus read enable |
| reg_wdata | output | 8 | Register-bus write data |
| reg_rdata | input | 8 | Register-bus read data, valid in the same cycle as the address |

## Verification
The hardest state to reach is one where the page-select register and the active page disagree. Getting there takes three steps. First, latch a page with a set pulse. Second, rewrite the register at 0xE1, which is only possible while page 0 is active. Third, access RAM before issuing the next set pulse. The bench builds this sequence explicitly and checks that the old page still steers the access. It then sweeps all 256 offsets under forced page 0 and under every latched code from 0 to 7. Each offset gets a write followed by a read, and the bench predicts the physical address, the strobes, the hole flag and the returned byte arithmetically.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    localparam int ADDR_W          = 8;
    localparam int DATA_W          = 8;
    localparam int PAGE_W          = 3;
    localparam int PHYS_W          = 10;
    localparam int REG_IDX_W       = 6;
    localparam int LAST_PAGE       = 2;
    localparam int LAST_PAGE_BYTES = 64;
    localparam int CTRL_BASE       = 'hC0;
    localparam int PSEL_ADDR       = 'hE1;

    typedef enum logic {
        PG_FORCED0,
        PG_LATCHED
    } pg_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_REG,
        TGT_PSEL,
        TGT_HOLE
    } tgt_e;
endpackage

// File: rtl/pdm_pagectl.sv
module pdm_pagectl
    import pdm_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic          psel_we_i,
    input  logic [PW-1:0] psel_wdata_i,
    output logic [PW-1:0] psel_q_o,
    output logic [PW-1:0] eff_page_o
);
    pg_state_e     state_q, state_d;
    logic [PW-1:0] psel_q;
    logic [PW-1:0] act_q;
    logic          load;

    assign load = set_i && !clr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_FORCED0: if (load)  state_d = PG_LATCHED;
            PG_LATCHED: if (clr_i) state_d = PG_FORCED0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_FORCED0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_q <= '0;
            act_q  <= '0;
        end else begin
            if (psel_we_i) psel_q <= psel_wdata_i;
            if (load)      act_q  <= psel_q;
        end
    end

    always_comb begin
        unique case (state_q)
            PG_FORCED0: eff_page_o = '0;
            PG_LATCHED: eff_page_o = act_q;
        endcase
    end

    assign psel_q_o = psel_q;
endmodule

// File: rtl/pdm_route.sv
module pdm_route
    import pdm_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int PW     = PAGE_W,
    parameter int XW     = PHYS_W,
    parameter int IW     = REG_IDX_W,
    parameter int LASTPG = LAST_PAGE,
    parameter int LASTB  = LAST_PAGE_BYTES,
    parameter int CBASE  = CTRL_BASE,
    parameter int PSADDR = PSEL_ADDR
) (
    input  logic [AW-1:0] addr_i,
    input  logic          access_i,
    input  logic [PW-1:0] page_i,
    output tgt_e          tgt_o,
    output logic [XW-1:0] phys_o,
    output logic [IW-1:0] idx_o
);
    localparam int                 HIW       = XW - AW;
    localparam logic [PW-1:0]      LAST_CODE = PW'(LASTPG);
    localparam logic [AW-1:0]      LAST_LIM  = AW'(LASTB);
    localparam logic [AW-1:0]      CTRL_LO   = AW'(CBASE);
    localparam logic [AW-1:0]      PS_OFF    = AW'(PSADDR);

    assign phys_o = {page_i[HIW-1:0], addr_i};
    assign idx_o  = addr_i[IW-1:0];

    always_comb begin
        tgt_o = TGT_NONE;
        if (access_i) begin
            if (page_i > LAST_CODE)
                tgt_o = TGT_HOLE;
            else if (page_i == LAST_CODE && addr_i >= LAST_LIM)
                tgt_o = TGT_HOLE;
            else if (page_i == '0 && addr_i >= CTRL_LO)
                tgt_o = (addr_i == PS_OFF) ? TGT_PSEL : TGT_REG;
            else
                tgt_o = TGT_RAM;
        end
    end
endmodule

// File: rtl/pdm_rdpath.sv
module pdm_rdpath
    import pdm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire_i,
    input  tgt_e          tgt_i,
    input  logic [DW-1:0] ram_rdata_i,
    input  logic [DW-1:0] reg_rdata_i,
    input  logic [PW-1:0] psel_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] sel_d;

    always_comb begin
        unique case (tgt_i)
            TGT_RAM:  sel_d = ram_rdata_i;
            TGT_REG:  sel_d = reg_rdata_i;
            TGT_PSEL: sel_d = {{(DW-PW){1'b0}}, psel_i};
            default:  sel_d = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_o <= '0;
        else if (rd_fire_i) rdata_o <= sel_d;
    end
endmodule

// File: rtl/paged_dmem_decoder.sv
module paged_dmem_decoder
    import pdm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PAGE_W,
    parameter int XW = PHYS_W,
    parameter int IW = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          unimpl,
    input  logic          gflag_set,
    input  logic          gflag_clr,
    output logic [XW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic [IW-1:0] reg_addr,
    output logic          reg_we,
    output logic          reg_re,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    logic [PW-1:0] eff_page;
    logic [PW-1:0] psel_q;
    tgt_e          tgt;
    logic          rd_fire;

    assign rd_fire = cpu_rd && !cpu_wr;

    pdm_pagectl #(.PW(PW)) u_pagectl (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (gflag_set),
        .clr_i        (gflag_clr),
        .psel_we_i    (cpu_wr && tgt == TGT_PSEL),
        .psel_wdata_i (cpu_wdata[PW-1:0]),
        .psel_q_o     (psel_q),
        .eff_page_o   (eff_page)
    );

    pdm_route #(.AW(AW), .PW(PW), .XW(XW), .IW(IW)) u_route (
        .addr_i   (cpu_addr),
        .access_i (cpu_rd || cpu_wr),
        .page_i   (eff_page),
        .tgt_o    (tgt),
        .phys_o   (ram_addr),
        .idx_o    (reg_addr)
    );

    pdm_rdpath #(.DW(DW), .PW(PW)) u_rdpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire_i   (rd_fire),
        .tgt_i       (tgt),
        .ram_rdata_i (ram_rdata),
        .reg_rdata_i (reg_rdata),
        .psel_i      (psel_q),
        .rdata_o     (cpu_rdata)
    );

    assign ram_we    = cpu_wr  && tgt == TGT_RAM;
    assign ram_re    = rd_fire && tgt == TGT_RAM;
    assign reg_we    = cpu_wr  && tgt == TGT_REG;
    assign reg_re    = rd_fire && tgt == TGT_REG;
    assign unimpl    = tgt == TGT_HOLE;
    assign ram_wdata = cpu_wdata;
    assign reg_wdata = cpu_wdata;
endmodule

// File: rtl/paged_dmem_decoder_chk.sv
module paged_dmem_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rd,
    input logic       cpu_wr,
    input logic       gflag_clr,
    input logic       unimpl,
    input logic       ram_we,
    input logic       ram_re,
    input logic       reg_we,
    input logic       reg_re,
    input logic [9:0] ram_addr,
    input logic [7:0] cpu_rdata
);
    // R8
    hole_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> !(ram_we || ram_re || reg_we || reg_re));

    // R8
    hole_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && unimpl) |=> cpu_rdata == 8'hFF);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !cpu_wr) |=> $stable(cpu_rdata));

    // R10
    idle_no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !unimpl);

    // R3
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((ram_we || ram_re) && (reg_we || reg_re)));

    // R5
    forced_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gflag_clr |=> ((ram_we || ram_re) -> ram_addr < 10'h100));
endmodule

bind paged_dmem_decoder paged_dmem_decoder_chk u_chk (.*);

// File: tb/paged_dmem_decoder_bench.sv
module paged_dmem_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       unimpl;
    logic       gflag_set = 1'b0, gflag_clr = 1'b0;
    logic [9:0] ram_addr;
    logic       ram_we, ram_re;
    logic [7:0] ram_wdata, ram_rdata;
    logic [5:0] reg_addr;
    logic       reg_we, reg_re;
    logic [7:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] ram_mdl [0:1023];
    logic [7:0] reg_mdl [0:63];
    logic [7:0] exp_ram [0:1023];
    logic [7:0] exp_reg [0:63];
    int         exp_psel = 0;

    always #4 clk = ~clk;

    paged_dmem_decoder u_paged_dmem_decoder (.*);

    assign ram_rdata = ram_mdl[ram_addr];
    assign reg_rdata = reg_mdl[reg_addr];
    always @(posedge clk) begin
        if (ram_we) ram_mdl[ram_addr] <= ram_wdata;
        if (reg_we) reg_mdl[reg_addr] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // 0 ram, 1 register window, 2 page-select, 3 hole
    function automatic int kind_of(input int p, input int a);
        if (p > 2) return 3;
        if (p == 2 && a >= 64) return 3;
        if (p == 0 && a >= 192) return (a == 225) ? 2 : 1;
        return 0;
    endfunction

    task automatic check_route(input int p, input int a, input bit wr);
        int    k = kind_of(p, a);
        string rq = (p == 0) ? "R2" : "R7";
        chk(ram_we == (wr && k == 0), rq, ram_we, wr && k == 0);
        chk(ram_re == (!wr && k == 0), rq, ram_re, !wr && k == 0);
        if (k == 0) chk(ram_addr == 10'(p * 256 + a), rq, ram_addr, p * 256 + a);
        chk(reg_we == (wr && k == 1), "R3", reg_we, wr && k == 1);
        chk(reg_re == (!wr && k == 1), "R3", reg_re, !wr && k == 1);
        if (k == 1) chk(reg_addr == 6'(a - 192), "R3", reg_addr, a - 192);
        chk(unimpl == (k == 3), "R8", unimpl, k == 3);
    endtask

    task automatic do_write(input int p, input int a, input int d);
        int k = kind_of(p, a);
        cpu_addr = 8'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
        #1 check_route(p, a, 1'b1);
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0;
        if (k == 0) exp_ram[p * 256 + a] = 8'(d);
        if (k == 1) exp_reg[a - 192] = 8'(d);
        if (k == 2) exp_psel = d & 7;
    endtask

    task automatic do_read(input int p, input int a, input string rq);
        int k = kind_of(p, a);
        int e;
        cpu_addr = 8'(a); cpu_rd = 1'b1;
        #1 check_route(p, a, 1'b0);
        @(posedge clk); @(negedge clk);
        cpu_rd = 1'b0;
        case (k)
            0: e = exp_ram[p * 256 + a];
            1: e = exp_reg[a - 192];
            2: e = exp_psel;
            default: e = 255;
        endcase
        #1 chk(cpu_rdata == 8'(e), rq, cpu_rdata, e);
    endtask

    task automatic pulse(input bit s, input bit c);
        gflag_set = s; gflag_clr = c;
        @(posedge clk); @(negedge clk);
        gflag_set = 1'b0; gflag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin ram_mdl[i] = 8'h00; exp_ram[i] = 8'h00; end
        for (int i = 0; i < 64; i++) begin reg_mdl[i] = 8'h00; exp_reg[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_rdata == 8'h00, "R1", cpu_rdata, 0);
        chk(unimpl == 1'b0, "R10", unimpl, 0);
        do_read(0, 225, "R1");
        // R4 only low bits stored; no bus strobes for page-select offset
        do_write(0, 225, 8'hFD);
        do_read(0, 225, "R4");
        // R9 hold across idle cycle
        @(negedge clk);
        chk(cpu_rdata == 8'h05, "R9", cpu_rdata, 5);
        // R5 flag clear forces page 0 despite code 5
        pulse(1'b0, 1'b1);
        do_write(0, 16, 8'h3C);
        do_read(0, 16, "R5");
        // R6 stale page-select value does not steer until next set
        do_write(0, 225, 0);
        pulse(1'b1, 1'b0);
        do_write(0, 225, 1);
        do_read(0, 16, "R6");
        pulse(1'b1, 1'b0);
        do_write(1, 16, 8'hA7);
        do_read(1, 16, "R6");
        pulse(1'b1, 1'b1);
        do_read(0, 16, "R6");
        // R10 idle cycle
        #1 chk(unimpl == 1'b0, "R10", unimpl, 0);
        // sweep: forced page 0, then each latched code 0..7
        for (int cfg = 0; cfg < 9; cfg++) begin
            int p;
            pulse(1'b0, 1'b1);
            if (cfg == 0) begin
                do_write(0, 225, 6);
                p = 0;
            end else begin
                p = cfg - 1;
                do_write(0, 225, p);
                pulse(1'b1, 1'b0);
            end
            for (int a = 0; a < 256; a++) begin
                if (p == 0 && a == 225) continue;
                do_write(p, a, (a * 7 + p * 37 + 8'h5A) & 255);
                do_read(p, a, kind_of(p, a) == 3 ? "R8" : "R9");
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule